// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block is the device side of a PCI type-0 configuration header. A requester issues one access per cycle on a simple strobe interface. Each access carries a byte offset into the 256-byte header, an access size of 1, 2 or 4 bytes, a write flag and write data. The block answers exactly one cycle later with read data and an error flag. It holds these registers:

- fixed identification words;
- a Status register whose new-capabilities bit reflects the build;
- one 64-bit memory base address register (BAR) that decodes a power-of-two window;
- a writable interrupt routing byte;
- a read-only chain of capabilities placed just after the standard header.

The window size, the capability count and each capability's identifier and payload are parameters. Enumeration software sizes the BAR by writing all ones to both halves and reading them back. It then walks the capability chain starting from the pointer byte. Decoding which function is addressed, memory traffic through the BAR and interrupt signalling are left to neighbouring logic.

Top module: `pci_cfg_endpoint`

## Requirements
- R1: A 4-byte read at offset 0x00 returns the vendor identifier in bits 15:0 and the device identifier in bits 31:16. A 1-byte read at offsets 0x00 to 0x03 returns that byte in bits 7:0, and a 2-byte read at 0x00 or 0x02 returns the matching half in bits 15:0. Response bits above the access size always read zero.
- R2: An access is rejected under either of two conditions. The first is a size code other than 1, 2 or 4. The second is an offset that is not a multiple of the size, for example 2 bytes at 0x01 or 4 bytes at 0x02. A rejected access returns cfg_err=1 and cfg_rdata=0, and it changes no register.
- R3: Every cycle with cfg_req=1 produces cfg_rsp=1 on the following cycle, and no other cycle produces cfg_rsp=1. A write returns cfg_rdata=0. A write takes effect for any access issued in the next cycle or later.
- R4: The lower BAR dword sits at offset 0x10. Its bits 3:0 always read 0x4: bit 0 is 0 for memory space, bits 2:1 are 2 for a 64-bit decoder, and bit 3 is 0 for non-prefetchable. Bits BAR_SIZE_LOG2-1 to 4 always read zero. Bits 31 to BAR_SIZE_LOG2 are writable and reset to zero. After all ones is written, clearing bits 3:0, inverting and adding one gives 2^BAR_SIZE_LOG2.
- R5: The upper BAR dword at offset 0x14 holds address bits 63:32. All of its bits are writable, and it resets to zero.
- R6: The interrupt line byte at offset 0x3C is fully writable and resets to zero. A 4-byte write at 0x3C changes only that byte. Bytes 0x3D to 0x3F keep reading zero.
- R7: The 2-byte Status register sits at offset 0x06. Its bit 4 (dword 0x04 bit 20) reads 1 when NUM_CAPS>0 and 0 when NUM_CAPS=0. All other bits of dword 0x04 read zero.
- R8: The pointer byte at offset 0x34 reads 0x40 when NUM_CAPS>0 and 0x00 when NUM_CAPS=0.
- R9: Capability i occupies the dword at 0x40+4*i. Byte 0 holds its identifier CAP_IDS[8i+7:8i], byte 1 holds the next pointer, and bytes 2 and 3 hold CAP_DATA[16i+15:16i] with the low byte first. The next pointer is 0x40+4*(i+1), except for the last capability, where it is 0x00.
- R10: Writes to read-only or unimplemented offsets have no effect and report no error. Unimplemented offsets read zero.
- R11: Writes of 1 or 2 bytes to a writable register update only the addressed bytes, which start at the offset's low two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Access strobe, one access per cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 8 | Byte offset into the header |
| cfg_size | input | 3 | Access size in bytes (1, 2 or 4) |
| cfg_wdata | input | 32 | Write data, least significant byte at the offset |
| cfg_rsp | output | 1 | Response valid, one cycle after cfg_req |
| cfg_rdata | output | 32 | Read data, right-justified |
| cfg_err | output | 1 | Access rejected for size or alignment |

## Verification
The bench drives all-ones sizing writes into both BAR halves. A design that stored the hardwired low bits, or that lost the type nibble, would report a wrong window size. It also issues misaligned and odd-sized writes aimed at the interrupt byte and the BAR. A block that only flagged the error would still corrupt those registers, and the next read would show it. A second instance is built with no capabilities, where a stale status bit or a non-zero pointer would send software into an empty chain. The chain walk checks that the final next pointer is zero, not a pointer back to 0x40 or past the list.

// File: rtl/pci_cfg_endpoint.sv
module pci_cfg_endpoint #(
  parameter logic [15:0] VENDOR_ID     = 16'hABCD,
  parameter logic [15:0] DEVICE_ID     = 16'h1234,
  parameter int          BAR_SIZE_LOG2 = 12,
  parameter int          NUM_CAPS      = 3,
  parameter logic [8*((NUM_CAPS>0)?NUM_CAPS:1)-1:0]  CAP_IDS  = 24'h07_05_09,
  parameter logic [16*((NUM_CAPS>0)?NUM_CAPS:1)-1:0] CAP_DATA = 48'h6655_4433_2211
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_req,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_off,
  input  logic [2:0]  cfg_size,
  input  logic [31:0] cfg_wdata,
  output logic        cfg_rsp,
  output logic [31:0] cfg_rdata,
  output logic        cfg_err
);

  localparam logic [5:0] DW_ID     = 6'h00;
  localparam logic [5:0] DW_STAT   = 6'h01;
  localparam logic [5:0] DW_BAR_LO = 6'h04;
  localparam logic [5:0] DW_BAR_HI = 6'h05;
  localparam logic [5:0] DW_CPTR   = 6'h0D;
  localparam logic [5:0] DW_IRQ    = 6'h0F;
  localparam int         CAP_DW0   = 16;
  localparam logic       HAS_CAPS  = (NUM_CAPS > 0);

  logic [31:BAR_SIZE_LOG2] bar_lo_q;
  logic [31:0]             bar_hi_q;
  logic [7:0]              irq_line_q;

  logic [1:0]  lane;
  logic [5:0]  dw;
  logic        aligned;
  logic [3:0]  be;
  logic [31:0] wd;
  logic        wr_en;
  logic [31:0] dword_val;
  logic [31:0] rd_mask;
  logic [31:0] rd_val;
  logic [31:0] bar_lo_nxt;

  assign lane  = cfg_off[1:0];
  assign dw    = cfg_off[7:2];
  assign wd    = cfg_wdata << {lane, 3'b000};
  assign wr_en = cfg_req && cfg_we && aligned;

  always_comb begin
    case (cfg_size)
      3'd1:    begin aligned = 1'b1;         be = 4'b0001 << lane; rd_mask = 32'h0000_00FF; end
      3'd2:    begin aligned = !cfg_off[0];  be = 4'b0011 << lane; rd_mask = 32'h0000_FFFF; end
      3'd4:    begin aligned = (lane == 2'd0); be = 4'b1111;       rd_mask = 32'hFFFF_FFFF; end
      default: begin aligned = 1'b0;         be = 4'b0000;         rd_mask = 32'h0000_0000; end
    endcase
  end

  function automatic logic [31:0] merge(input logic [31:0] old_v, input logic [31:0] new_v,
                                        input logic [3:0] en);
    for (int k = 0; k < 4; k++)
      merge[8*k +: 8] = en[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
  endfunction

  function automatic logic [31:0] cap_word(input int i);
    logic [7:0] nxt;
    nxt = (i == NUM_CAPS - 1) ? 8'h00 : 8'(64 + 4 * (i + 1));
    return {CAP_DATA[16*i +: 16], nxt, CAP_IDS[8*i +: 8]};
  endfunction

  always_comb begin
    dword_val = 32'h0;
    case (dw)
      DW_ID:     dword_val = {DEVICE_ID, VENDOR_ID};
      DW_STAT:   dword_val = {11'd0, HAS_CAPS, 20'd0};
      DW_BAR_LO: dword_val = {bar_lo_q, {BAR_SIZE_LOG2{1'b0}}} | 32'h0000_0004;
      DW_BAR_HI: dword_val = bar_hi_q;
      DW_CPTR:   dword_val = {24'd0, HAS_CAPS ? 8'h40 : 8'h00};
      DW_IRQ:    dword_val = {24'd0, irq_line_q};
      default:
        for (int i = 0; i < NUM_CAPS; i++)
          if (dw == 6'(CAP_DW0 + i)) dword_val = cap_word(i);
    endcase
  end

  assign rd_val     = (dword_val >> {lane, 3'b000}) & rd_mask;
  assign bar_lo_nxt = merge({bar_lo_q, {BAR_SIZE_LOG2{1'b0}}}, wd, be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_lo_q   <= '0;
      bar_hi_q   <= '0;
      irq_line_q <= '0;
    end else if (wr_en) begin
      if (dw == DW_BAR_LO) bar_lo_q <= bar_lo_nxt[31:BAR_SIZE_LOG2];
      if (dw == DW_BAR_HI) bar_hi_q <= merge(bar_hi_q, wd, be);
      if (dw == DW_IRQ && be[0]) irq_line_q <= wd[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rsp   <= 1'b0;
      cfg_err   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      cfg_rsp   <= cfg_req;
      cfg_err   <= cfg_req && !aligned;
      cfg_rdata <= (cfg_req && aligned && !cfg_we) ? rd_val : 32'h0;
    end
  end

endmodule

// File: rtl/pci_cfg_endpoint_chk.sv
module pci_cfg_endpoint_chk #(
  parameter logic [15:0] VENDOR_ID     = 16'hABCD,
  parameter logic [15:0] DEVICE_ID     = 16'h1234,
  parameter int          BAR_SIZE_LOG2 = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic [7:0]  cfg_off,
  input logic [2:0]  cfg_size,
  input logic        cfg_rsp,
  input logic [31:0] cfg_rdata,
  input logic        cfg_err
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> cfg_rsp); // R3
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req |=> !cfg_rsp); // R3
  AST_MISALIGNED_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_size == 3'd4 && cfg_off[1:0] != 2'd0) |=> cfg_err); // R2
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (cfg_rdata == 32'h0)); // R2
  AST_ID_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we && cfg_size == 3'd4 && cfg_off == 8'h00)
      |=> (cfg_rdata == {DEVICE_ID, VENDOR_ID})); // R1
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_size == 3'd1) |=> (cfg_rdata[31:8] == 24'h0)); // R1
  AST_BAR_TYPE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we && cfg_size == 3'd4 && cfg_off == 8'h10)
      |=> (cfg_rdata[3:0] == 4'h4)); // R4
  AST_BAR_SIZE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we && cfg_size == 3'd4 && cfg_off == 8'h10)
      |=> (cfg_rdata[BAR_SIZE_LOG2-1:4] == '0)); // R4

endmodule

bind pci_cfg_endpoint pci_cfg_endpoint_chk #(
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_off(cfg_off),
  .cfg_size(cfg_size), .cfg_rsp(cfg_rsp), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err)
);

// File: tb/pci_cfg_endpoint_tb_top.sv
module pci_cfg_endpoint_tb_top;

  localparam logic [15:0] VID  = 16'hABCD;
  localparam logic [15:0] DID  = 16'h1234;
  localparam int          L    = 12;
  localparam int          NCAP = 3;
  localparam logic [23:0] IDS  = 24'h07_05_09;
  localparam logic [47:0] DAT  = 48'h6655_4433_2211;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [2:0]  cfg_size = 3'd4;
  logic [31:0] cfg_wdata = '0;
  logic        rsp_a, err_a, rsp_b, err_b;
  logic [31:0] rdata_a, rdata_b;

  always #2.5 clk = ~clk;

  pci_cfg_endpoint #(.VENDOR_ID(VID), .DEVICE_ID(DID), .BAR_SIZE_LOG2(L), .NUM_CAPS(NCAP),
                     .CAP_IDS(IDS), .CAP_DATA(DAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rsp(rsp_a), .cfg_rdata(rdata_a),
    .cfg_err(err_a));

  pci_cfg_endpoint #(.VENDOR_ID(VID), .DEVICE_ID(DID), .BAR_SIZE_LOG2(L), .NUM_CAPS(0),
                     .CAP_IDS(8'h00), .CAP_DATA(16'h0000)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rsp(rsp_b), .cfg_rdata(rdata_b),
    .cfg_err(err_b));

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string tb_tag = "";

  logic [7:0]  m_bar [8];
  logic [7:0]  m_irq;
  logic        exp_rsp = 1'b0;
  logic        exp_err = 1'b0;
  logic [31:0] exp_a = '0, exp_b = '0;
  string       exp_tag = "R3";

  function automatic bit is_ok(input logic [7:0] off, input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2 && !off[0]) || (sz == 3'd4 && off[1:0] == 2'd0);
  endfunction

  // R4: address bits below the window size are not writable
  function automatic logic [7:0] lo_mask(input int j);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((8 * j + b) >= L);
    return m;
  endfunction

  function automatic logic [7:0] mbyte(input int a, input bit nc);
    int k;
    if (a < 2) return VID[8*a +: 8];
    if (a < 4) return DID[8*(a-2) +: 8];
    if (a == 6) return nc ? 8'h00 : 8'h10;
    if (a >= 16 && a < 20) return (m_bar[a-16] & lo_mask(a-16)) | ((a == 16) ? 8'h04 : 8'h00);
    if (a >= 20 && a < 24) return m_bar[a-16];
    if (a == 8'h34) return nc ? 8'h00 : 8'h40;
    if (a == 8'h3C) return m_irq;
    if (!nc && a >= 64 && a < 64 + 4 * NCAP) begin
      k = (a - 64) / 4;
      case (a % 4)
        0: return IDS[8*k +: 8];
        1: return (k == NCAP - 1) ? 8'h00 : 8'(64 + 4 * (k + 1));
        2: return DAT[16*k +: 8];
        default: return DAT[16*k+8 +: 8];
      endcase
    end
    return 8'h00;
  endfunction

  function automatic string auto_tag(input logic [7:0] off, input logic [2:0] sz, input bit we);
    if (!is_ok(off, sz)) return "R2";
    if (we && sz != 3'd4) return "R11";
    if (off < 8'h04) return "R1";
    if (off < 8'h08) return "R7";
    if (off >= 8'h10 && off < 8'h14) return "R4";
    if (off >= 8'h14 && off < 8'h18) return "R5";
    if (off >= 8'h34 && off < 8'h38) return "R8";
    if (off >= 8'h3C && off < 8'h40) return "R6";
    if (off >= 8'h40 && off < 8'h4C) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_bar[i] = 8'h00;
      m_irq = 8'h00;
      exp_rsp <= 1'b0;
      exp_err <= 1'b0;
      exp_a <= '0;
      exp_b <= '0;
    end else begin
      logic [31:0] ra, rb;
      bit ok;
      ra = '0;
      rb = '0;
      ok = is_ok(cfg_off, cfg_size);
      exp_rsp <= cfg_req;
      exp_err <= cfg_req && !ok;
      if (cfg_req && ok && !cfg_we)
        for (int k = 0; k < int'(cfg_size); k++) begin
          ra[8*k +: 8] = mbyte(int'(cfg_off) + k, 1'b0);
          rb[8*k +: 8] = mbyte(int'(cfg_off) + k, 1'b1);
        end
      exp_a <= ra;
      exp_b <= rb;
      exp_tag <= (tb_tag != "") ? tb_tag : auto_tag(cfg_off, cfg_size, cfg_we);
      if (cfg_req && ok && cfg_we)
        for (int k = 0; k < int'(cfg_size); k++) begin
          int a;
          a = int'(cfg_off) + k;
          if (a >= 16 && a < 24) m_bar[a-16] = cfg_wdata[8*k +: 8];
          if (a == 8'h3C) m_irq = cfg_wdata[8*k +: 8];
        end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rsp_a !== exp_rsp || rsp_b !== exp_rsp) begin
        fails++;
        $display("FAIL R3: rsp=%0b/%0b expected %0b", rsp_a, rsp_b, exp_rsp);
      end else if (exp_rsp) begin
        if (err_a !== exp_err || err_b !== exp_err) begin
          fails++;
          $display("FAIL R2 (%s): err=%0b/%0b expected %0b", exp_tag, err_a, err_b, exp_err);
        end
        if (rdata_a !== exp_a) begin
          fails++;
          $display("FAIL %s: rdata=%h expected %h", exp_tag, rdata_a, exp_a);
        end
        if (rdata_b !== exp_b) begin
          fails++;
          $display("FAIL %s (no caps): rdata=%h expected %h", exp_tag, rdata_b, exp_b);
        end
      end
    end
  end

  task automatic acc(input bit we, input logic [7:0] off, input logic [2:0] sz,
                     input logic [31:0] d, input string tag);
    cfg_req = 1'b1; cfg_we = we; cfg_off = off; cfg_size = sz; cfg_wdata = d; tb_tag = tag;
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_req = 1'b0; cfg_we = 1'b0; tb_tag = "";
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state of writable registers: R4 R5 R6
    acc(0, 8'h10, 4, 0, "R4");
    acc(0, 8'h14, 4, 0, "R5");
    acc(0, 8'h3C, 4, 0, "R6");
    idle();
    // R1 identification, dword, half and byte lanes
    acc(0, 8'h00, 4, 0, "R1");
    for (int i = 0; i < 4; i++) acc(0, 8'(i), 1, 0, "R1");
    acc(0, 8'h00, 2, 0, "R1");
    acc(0, 8'h02, 2, 0, "R1");
    // R2 misaligned and bad sizes, including writes that must not land
    acc(0, 8'h01, 2, 0, "R2");
    acc(0, 8'h02, 4, 0, "R2");
    acc(0, 8'h00, 3, 0, "R2");
    acc(1, 8'h3E, 4, 32'hFFFF_FFFF, "R2");
    acc(1, 8'h11, 2, 32'hFFFF_FFFF, "R2");
    acc(1, 8'h14, 0, 32'hFFFF_FFFF, "R2");
    acc(0, 8'h3C, 4, 0, "R2");
    acc(0, 8'h10, 4, 0, "R2");
    acc(0, 8'h14, 4, 0, "R2");
    // R4 R5 sizing with all ones, then read back immediately (R3 timing)
    acc(1, 8'h10, 4, 32'hFFFF_FFFF, "R4");
    acc(1, 8'h14, 4, 32'hFFFF_FFFF, "R5");
    acc(0, 8'h10, 4, 0, "R4");
    acc(0, 8'h14, 4, 0, "R5");
    acc(1, 8'h10, 4, 32'hDEAD_BEEF, "R4");
    acc(0, 8'h10, 4, 0, "R4");
    // R11 partial writes into the BAR
    acc(1, 8'h16, 2, 32'h0000_5A5A, "R11");
    acc(1, 8'h13, 1, 32'h0000_0011, "R11");
    acc(0, 8'h14, 4, 0, "R11");
    acc(0, 8'h10, 4, 0, "R11");
    // R6 interrupt line
    acc(1, 8'h3C, 1, 32'h0000_00AA, "R6");
    acc(0, 8'h3C, 1, 0, "R6");
    acc(1, 8'h3C, 4, 32'h5555_5555, "R6");
    acc(0, 8'h3C, 4, 0, "R6");
    // R7 status, R8 pointer, R9 chain walk
    acc(0, 8'h04, 4, 0, "R7");
    acc(0, 8'h06, 2, 0, "R7");
    acc(0, 8'h34, 1, 0, "R8");
    for (int i = 0; i < NCAP + 1; i++) acc(0, 8'(64 + 4 * i), 4, 0, "R9");
    acc(0, 8'h49, 1, 0, "R9");
    // R10 read-only and unimplemented offsets
    acc(1, 8'h00, 4, 32'h0, "R10");
    acc(1, 8'h34, 1, 32'hFF, "R10");
    acc(1, 8'h40, 4, 32'h0, "R10");
    acc(1, 8'h80, 4, 32'hFFFF_FFFF, "R10");
    acc(0, 8'h00, 4, 0, "R10");
    acc(0, 8'h34, 1, 0, "R10");
    acc(0, 8'h40, 4, 0, "R10");
    acc(0, 8'h80, 4, 0, "R10");
    idle();
    idle();
    // mixed traffic with gaps
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] sz;
      case ($urandom_range(0, 7))
        0: sz = 3'd1; 1, 2: sz = 3'd2; 7: sz = 3'($urandom_range(0, 7)); default: sz = 3'd4;
      endcase
      if ($urandom_range(0, 5) == 0) idle();
      else acc($urandom_range(0, 2) == 0, 8'($urandom_range(0, 95)), sz, $urandom, "");
    end
    idle();
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule